// File: doc/BRIEF.md
# Three-Wire Control-Bus Slave

This block lets a microcontroller reach a bank of 16-bit control registers over a three-wire serial bus made of a data line, a mode line and a clock line. The system clock oversamples all three lines. While the mode line is low the master sends an address byte, which selects one slave and chooses between writing and reading. While the mode line is high the master moves data bytes. All bytes travel least-significant bit first.

A write names a register and then sends its new value, high byte first. A read takes two transfers. A prepare-read names the register. A later read transfer makes the slave drive the data line, with an output enable, and send the register index with a validity flag, then the register contents. Two strap pins set part of the device address, so up to four slaves can share one bus. The register contents are available in parallel on `cfg_o`. Every write also gives a one-cycle strobe with the index and the value written.

Top module: `ctl3w_slave`

## Requirements
- R1: An address byte selects this slave only when bits 7..4 are 4'b0001, bit 3 equals strap_i[1] and bit 2 equals strap_i[0]. Bytes are assembled least-significant bit first. Any other address leaves the slave unselected, and the transfer that follows changes nothing.
- R2: Address bits 1..0 form the operation code. 2'b10 selects write or prepare-read, and 2'b11 selects read. The codes 2'b00 and 2'b01 are ignored, so the data phase that follows changes nothing.
- R3: After reset the slave ignores all traffic until the bus clock has made one rising edge. The bit on that edge is discarded, and this wake-up happens only once per reset.
- R4: In a write, data byte 0 has bit 0 = 0 and carries the register index in bits 7..1. Byte 1 is the high byte and byte 2 is the low byte. Only after byte 2 does wr_stb_o pulse high for one cycle, with wr_idx_o and wr_data_o, and the register take the value. A transfer that ends after the high byte writes nothing.
- R5: Bytes after the low byte in the same data phase are ignored. A write to an index of NREG or more changes no register and gives no strobe.
- R6: A data byte 0 with bit 0 = 1 (prepare-read) stores bits 7..1 as the read pointer. The pointer persists across transfers until the next prepare-read.
- R7: A read data phase returns 24 bits. The first byte has the read pointer in bits 7..1 and, in bit 0, 0 if the index holds a register or 1 if it does not. Then come the high byte and the low byte, both 0 for an invalid index. After reset the pointer is 127.
- R8: Bits are taken on rising bus-clock edges. During a read data phase bus_data_oe_o is high, and each new output bit appears after a falling edge and stays valid through the next rising edge. The enable drops after the 24th bit or when the mode line goes low.
- R9: Any change of the mode line discards a partly received byte. The mode line going low ends the data phase and the selection.
- R10: After reset bus_data_oe_o and wr_stb_o are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock line, idles high |
| bus_mode_i | input | 1 | Mode line: low for the address phase, high for the data phase |
| bus_data_i | input | 1 | Data line as seen by the slave |
| bus_data_o | output | 1 | Data bit the slave drives during reads |
| bus_data_oe_o | output | 1 | Output enable for bus_data_o |
| strap_i | input | 2 | Strap pins for address bits 3..2 |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_idx_o | output | 7 | Register index of the write |
| wr_data_o | output | 16 | Value written |
| cfg_o | output | NREG*16 | All register contents, register r at bits r*16 +: 16 |

## Verification
The hardest state to reach is the slave before wake-up. It exists only between reset and the first bus-clock rising edge, and the only visible sign of it is a lost bit. The bench resets the block and at once sends a full write with no wake pulse. The first address bit is then dropped, the address byte is left one bit short when the mode line rises, and the register must stay 0. A second reset with a single wake pulse, followed by a read with no prepare-read, reaches the reset value of the read pointer.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int unsigned IDX_W   = 7;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned FRAME_W = BYTE_W + REG_W;

  localparam logic [1:0] OPC_WRITE = 2'b10;
  localparam logic [1:0] OPC_READ  = 2'b11;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_WRITE = 2'd1,
    SEL_READ  = 2'd2
  } sel_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic mode_chg;
    logic mode;
    logic bit_v;
  } bus_ev_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync
  import ctl3w_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bus_clk_i,
  input  logic    bus_mode_i,
  input  logic    bus_data_i,
  output bus_ev_t ev_o
);
  localparam int unsigned LINES = 3;
  // line 0 = clock (idles high), 1 = mode, 2 = data
  localparam logic [LINES-1:0] IDLE_LVL = 3'b001;

  logic [LINES-1:0] raw, synced;
  logic clk_d, mode_d;

  assign raw = {bus_data_i, bus_mode_i, bus_clk_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{IDLE_LVL[g]}};
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d  <= 1'b1;
      mode_d <= 1'b0;
    end else begin
      clk_d  <= synced[0];
      mode_d <= synced[1];
    end
  end

  assign ev_o.rise     = synced[0] & ~clk_d;
  assign ev_o.fall     = ~synced[0] & clk_d;
  assign ev_o.mode_chg = synced[1] ^ mode_d;
  assign ev_o.mode     = synced[1];
  assign ev_o.bit_v    = synced[2];
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
  import ctl3w_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [IDX_W-1:0]        ridx_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic                    rvalid_o,
  output logic [NREG*REG_W-1:0]   regs_o
);
  localparam int unsigned SEL_W = $clog2(NREG);

  logic [REG_W-1:0] regs_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[r] <= '0;
      else if (we_i && widx_i == IDX_W'(r)) regs_q[r] <= wdata_i;
    end
    assign regs_o[r*REG_W +: REG_W] = regs_q[r];
  end

  assign rvalid_o = 32'(ridx_i) < NREG;
  assign rdata_o  = rvalid_o ? regs_q[ridx_i[SEL_W-1:0]] : '0;
endmodule

// File: rtl/ctl3w_proto.sv
module ctl3w_proto
  import ctl3w_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter logic [3:0]  DEV_HI = 4'b0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  bus_ev_t            ev_i,
  input  logic [1:0]         strap_i,
  input  logic [REG_W-1:0]   rd_data_i,
  input  logic               rd_valid_i,
  output logic [IDX_W-1:0]   rd_ptr_o,
  output logic               wr_stb_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [REG_W-1:0]   wr_data_o,
  output logic               sda_o,
  output logic               sda_oe_o,
  output logic               awake_o
);
  localparam logic [4:0] TX_BITS = 5'(FRAME_W);

  sel_e              sel;
  logic              awake;
  logic [2:0]        cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [1:0]        bcnt;
  logic              is_wr;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] hi_q;
  logic [IDX_W-1:0]  rd_ptr;
  logic [FRAME_W-1:0] tx_sr;
  logic [4:0]        tx_left;
  logic              tx_on;
  logic [BYTE_W-1:0] byte_w;

  function automatic logic idx_ok(input logic [IDX_W-1:0] i);
    return 32'(i) < NREG;
  endfunction

  assign byte_w = {ev_i.bit_v, rx_sr};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel <= SEL_NONE; awake <= 1'b0; cnt <= '0; rx_sr <= '0; bcnt <= '0;
      is_wr <= 1'b0; idx_q <= '0; hi_q <= '0; rd_ptr <= '1;
      tx_sr <= '0; tx_left <= '0; tx_on <= 1'b0;
      wr_stb_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (!awake) begin
        if (ev_i.rise) awake <= 1'b1;
      end else if (ev_i.mode_chg) begin
        cnt  <= '0;
        bcnt <= '0;
        if (!ev_i.mode) begin
          sel   <= SEL_NONE;
          tx_on <= 1'b0;
        end else if (sel == SEL_READ) begin
          tx_on   <= 1'b1;
          tx_left <= TX_BITS;
          tx_sr   <= {rd_data_i[7:0], rd_data_i[15:8], rd_ptr, ~rd_valid_i};
        end
      end else if (ev_i.rise) begin
        rx_sr <= byte_w[BYTE_W-1:1];
        cnt   <= cnt + 3'd1;
        if (ev_i.mode && tx_on && tx_left != '0) tx_left <= tx_left - 5'd1;
        if (!ev_i.mode && cnt == 3'd0) sel <= SEL_NONE;
        if (cnt == 3'd7) begin
          if (!ev_i.mode) begin
            if (byte_w[7:2] != {DEV_HI, strap_i}) sel <= SEL_NONE;
            else if (byte_w[1:0] == OPC_WRITE)    sel <= SEL_WRITE;
            else if (byte_w[1:0] == OPC_READ)     sel <= SEL_READ;
            else                                  sel <= SEL_NONE;
          end else if (sel == SEL_WRITE) begin
            if (bcnt != 2'd3) bcnt <= bcnt + 2'd1;
            case (bcnt)
              2'd0: begin
                is_wr <= ~byte_w[0];
                idx_q <= byte_w[7:1];
                if (byte_w[0]) rd_ptr <= byte_w[7:1];
              end
              2'd1: hi_q <= byte_w;
              2'd2: if (is_wr && idx_ok(idx_q)) begin
                wr_stb_o  <= 1'b1;
                wr_idx_o  <= idx_q;
                wr_data_o <= {hi_q, byte_w};
              end
              default: ;
            endcase
          end
        end
      end else if (ev_i.fall && tx_on && tx_left < TX_BITS && tx_left != '0) begin
        tx_sr <= tx_sr >> 1;
      end
    end
  end

  assign sda_oe_o = tx_on && (tx_left != '0);
  assign sda_o    = sda_oe_o & tx_sr[0];
  assign rd_ptr_o = rd_ptr;
  assign awake_o  = awake;
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
  import ctl3w_pkg::*;
#(
  parameter int unsigned NREG        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_HI      = 4'b0001
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_clk_i,
  input  logic                  bus_mode_i,
  input  logic                  bus_data_i,
  output logic                  bus_data_o,
  output logic                  bus_data_oe_o,
  input  logic [1:0]            strap_i,
  output logic                  wr_stb_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [REG_W-1:0]      wr_data_o,
  output logic [NREG*REG_W-1:0] cfg_o
);
  bus_ev_t          ev;
  logic             awake;
  logic [IDX_W-1:0] rd_ptr;
  logic [REG_W-1:0] rd_data;
  logic             rd_valid;

  ctl3w_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_clk_i(bus_clk_i), .bus_mode_i(bus_mode_i), .bus_data_i(bus_data_i),
    .ev_o(ev)
  );

  ctl3w_proto #(.NREG(NREG), .DEV_HI(DEV_HI)) i_proto (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev), .strap_i(strap_i),
    .rd_data_i(rd_data), .rd_valid_i(rd_valid), .rd_ptr_o(rd_ptr),
    .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .sda_o(bus_data_o), .sda_oe_o(bus_data_oe_o), .awake_o(awake)
  );

  ctl3w_regbank #(.NREG(NREG)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_stb_o), .widx_i(wr_idx_o), .wdata_i(wr_data_o),
    .ridx_i(rd_ptr), .rdata_o(rd_data), .rvalid_o(rd_valid),
    .regs_o(cfg_o)
  );
endmodule

// File: rtl/ctl3w_slave_chk.sv
module ctl3w_slave_chk
  import ctl3w_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_stb_o,
  input logic [IDX_W-1:0]      wr_idx_o,
  input logic [NREG*REG_W-1:0] cfg_o,
  input logic                  bus_data_oe_o,
  input logic                  mode_s,
  input logic                  awake
);
  // R8: the line is driven only in a data phase
  p_drive_in_data_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> $past(mode_s));

  // R3: nothing happens before wake-up
  p_quiet_asleep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake |-> (!bus_data_oe_o && !wr_stb_o));

  // R5: strobes only for existing registers
  p_strobe_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (32'(wr_idx_o) < NREG));

  // R4: the strobe is a single-cycle pulse
  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  // R4: registers change only after a strobe
  p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |=> $stable(cfg_o));
endmodule

bind ctl3w_slave ctl3w_slave_chk #(.NREG(NREG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o),
  .cfg_o(cfg_o), .bus_data_oe_o(bus_data_oe_o), .mode_s(ev.mode), .awake(awake)
);

// File: tb/test_ctl3w_slave.sv
`timescale 1ns/1ps
module test_ctl3w_slave;
  localparam int NREG = 8;
  localparam int HP   = 8;
  localparam int WD   = 150000;

  typedef struct packed {
    logic        is_rd;
    logic [6:0]  idx;
    logic [15:0] val;
    logic        ok;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b0, 7'd2,   16'hA55A, 1'b1},
    '{1'b0, 7'd5,   16'h1234, 1'b1},
    '{1'b0, 7'd7,   16'hFFFF, 1'b1},
    '{1'b1, 7'd2,   16'hA55A, 1'b1},
    '{1'b1, 7'd5,   16'h1234, 1'b1},
    '{1'b1, 7'd9,   16'h0000, 1'b0},
    '{1'b1, 7'd7,   16'hFFFF, 1'b1},
    '{1'b1, 7'd0,   16'h0000, 1'b1},
    '{1'b1, 7'd127, 16'h0000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_clk = 1'b1, bus_mode = 1'b0, bus_data = 1'b0;
  logic [1:0] strap = 2'b00;
  logic bus_q, bus_oe, wr_stb;
  logic [6:0] wr_idx;
  logic [15:0] wr_data;
  logic [NREG*16-1:0] cfg;
  int n_chk = 0, n_fail = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl3w_slave #(.NREG(NREG)) i_ctl3w_slave (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bus_clk), .bus_mode_i(bus_mode),
    .bus_data_i(bus_data), .bus_data_o(bus_q), .bus_data_oe_o(bus_oe),
    .strap_i(strap), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .cfg_o(cfg)
  );

  always @(posedge clk) if (rst_n && wr_stb) stb_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); bus_clk = 1'b0; bus_data = b;
    idle(HP); bus_clk = 1'b1; idle(HP);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) bit_out(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] b, inout logic oe_all);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bus_clk = 1'b0;
      idle(HP);
      b[i] = bus_q; oe_all = oe_all & bus_oe;
      bus_clk = 1'b1; idle(HP);
    end
  endtask

  task automatic set_mode(input logic m);
    idle(HP); bus_mode = m; idle(HP);
  endtask

  task automatic wr_reg(input logic [7:0] adr, input logic [6:0] idx, input logic [15:0] v);
    set_mode(1'b0); send_byte(adr); set_mode(1'b1);
    send_byte({idx, 1'b0}); send_byte(v[15:8]); send_byte(v[7:0]);
    set_mode(1'b0);
  endtask

  task automatic prep(input logic [6:0] idx);
    set_mode(1'b0); send_byte(8'h12); set_mode(1'b1);
    send_byte({idx, 1'b1}); set_mode(1'b0);
  endtask

  task automatic rd_reg(output logic [7:0] ib, output logic [15:0] v, output logic oe_all);
    logic [7:0] h, l;
    oe_all = 1'b1;
    set_mode(1'b0); send_byte(8'h13); set_mode(1'b1);
    recv_byte(ib, oe_all); recv_byte(h, oe_all); recv_byte(l, oe_all);
    v = {h, l};
    set_mode(1'b0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; bus_clk = 1'b1; bus_mode = 1'b0; bus_data = 1'b0;
    idle(4); rst_n = 1'b1; idle(4);
  endtask

  function automatic logic [15:0] reg_of(input int i);
    return cfg[i*16 +: 16];
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] ib;
    logic [15:0] v;
    logic oe_all;
    logic [NREG*16-1:0] snap;
    int s0;

    do_reset();
    check("R10 oe after reset", 32'(bus_oe), 0);
    check("R10 strobe after reset", 32'(wr_stb), 0);
    check("R10 regs after reset", 32'(cfg != '0), 0);

    // R3: no wake pulse, the first bit is lost and the write misses
    wr_reg(8'h12, 7'd1, 16'hBEEF);
    check("R3 write before wake ignored", 32'(reg_of(1)), 0);
    check("R3 no strobe before wake", stb_cnt, 0);
    wr_reg(8'h12, 7'd1, 16'hBEEF);
    check("R4 write after wake", 32'(reg_of(1)), 32'h0000BEEF);
    check("R4 one strobe", stb_cnt, 1);

    // R7: read pointer reset value, single wake pulse
    do_reset();
    check("R10 reg cleared by reset", 32'(reg_of(1)), 0);
    bit_out(1'b0);
    rd_reg(ib, v, oe_all);
    check("R7 pointer reset index byte", 32'(ib), 32'hFF);
    check("R7 invalid index data", 32'(v), 0);
    check("R8 oe during read", 32'(oe_all), 1);
    check("R8 oe released", 32'(bus_oe), 0);

    // table walk: R4, R6, R7
    for (int k = 0; k < 9; k++) begin
      if (!TBL[k].is_rd) begin
        wr_reg(8'h12, TBL[k].idx, TBL[k].val);
        check("R4 table write", 32'(reg_of(int'(TBL[k].idx))), 32'(TBL[k].val));
      end else begin
        prep(TBL[k].idx);
        rd_reg(ib, v, oe_all);
        check("R6 R7 table index byte", 32'(ib), 32'({TBL[k].idx, ~TBL[k].ok}));
        check("R7 table data", 32'(v), 32'(TBL[k].val));
      end
    end

    // R1: strap matching
    wr_reg(8'h16, 7'd3, 16'h1111);
    check("R1 other strap ignored", 32'(reg_of(3)), 0);
    strap = 2'b01;
    wr_reg(8'h16, 7'd3, 16'h2222);
    check("R1 matching strap", 32'(reg_of(3)), 32'h2222);
    wr_reg(8'h12, 7'd3, 16'h3333);
    check("R1 old address ignored", 32'(reg_of(3)), 32'h2222);
    strap = 2'b00;

    // R2: unused operation codes
    wr_reg(8'h10, 7'd4, 16'h3333);
    wr_reg(8'h11, 7'd4, 16'h4444);
    check("R2 unused codes ignored", 32'(reg_of(4)), 0);

    // R9: mode change in the middle of a byte
    s0 = stb_cnt;
    set_mode(1'b0); send_byte(8'h12); set_mode(1'b1);
    send_byte({7'd6, 1'b0}); send_byte(8'hAB); send_bits(8'hCD, 4);
    set_mode(1'b0);
    check("R9 partial byte aborted", 32'(reg_of(6)), 0);
    // R4: only the high byte arrives
    set_mode(1'b0); send_byte(8'h12); set_mode(1'b1);
    send_byte({7'd6, 1'b0}); send_byte(8'hAB);
    set_mode(1'b0);
    check("R4 no strobe without low byte", stb_cnt, s0);
    // R9: partial address byte, then the data phase
    set_mode(1'b0); send_bits(8'h12, 5); set_mode(1'b1);
    send_byte({7'd6, 1'b0}); send_byte(8'h77); send_byte(8'h88);
    set_mode(1'b0);
    check("R9 partial address aborted", 32'(reg_of(6)), 0);

    // R5: extra bytes, out-of-range index
    s0 = stb_cnt;
    set_mode(1'b0); send_byte(8'h12); set_mode(1'b1);
    send_byte({7'd6, 1'b0}); send_byte(8'h5A); send_byte(8'hC3);
    send_byte(8'h11); send_byte(8'h22);
    set_mode(1'b0);
    check("R5 extra bytes ignored", 32'(reg_of(6)), 32'h5AC3);
    check("R5 single strobe", stb_cnt, s0 + 1);
    snap = cfg;
    wr_reg(8'h12, 7'd20, 16'h9999);
    check("R5 out-of-range write", 32'(cfg != snap), 0);
    check("R5 no strobe out of range", stb_cnt, s0 + 1);

    // R6: pointer persists over writes
    prep(7'd6);
    wr_reg(8'h12, 7'd0, 16'h0F0F);
    rd_reg(ib, v, oe_all);
    check("R6 pointer kept", 32'(ib), 32'h0C);
    check("R6 data of kept pointer", 32'(v), 32'h5AC3);

    done = 1'b1;
    finish_run();
  end
endmodule